// File: doc/BRIEF.md
# DRAM Write Cycle Sequencer

This block drives the pins of an external DRAM for write accesses over a 16-bit data path. The 16 bits sit on the upper byte lanes of a wider bus: lane H is D31..D24 and lane L is D23..D16. Each bus cycle has five states, Q1 to Q5. The multiplexed address pins show a row address first and then a column address. The chip select, RAS, write-enable and CAS strobes step through a fixed pattern within those states. A 32-bit write is issued as two half-word cycles back to back.

The lane strobes can be wired in two ways. In one-CAS mode a single CAS is shared and there is one write enable per lane. In two-CAS mode a single write enable is shared and there is one CAS per lane. The mode is chosen for each request. A one-clock pulse on `done` marks the end of an access. A request is only taken while the sequencer is idle.

Top module: `dram_wr_seq`

## Requirements
- R1: A request is accepted only while the sequencer is idle (no cycle in Q1..Q5). The clock edge that accepts it is followed by Q1. Each of Q1..Q5 then lasts exactly one clock, in that order. A request raised during a busy cycle is ignored and is not remembered.
- R2: `addr` is a byte address. Bit 0 is the byte offset, bits [9:1] form the column and bits [20:10] form the row. For a half-word or byte access, the half-word address is addr[20:1]. `ma` carries the row in Q1 and Q2 and the column in Q3, Q4 and Q5. `ma` is zero when idle.
- R3: `cs_n` is low in every Q state. `ras_n` is low in Q2..Q5. `rd_n` stays high at all times. All strobes are high when idle.
- R4: `dq_oe` is high in Q1..Q5 and low otherwise, and `dq_o` is zero while `dq_oe` is low. In a half-word cycle, `dq_o` is wdata[15:0], with bits [15:8] on lane H. In a byte cycle, wdata[7:0] appears on both lanes.
- R5: With `strb_mode`=0 (one CAS), the shared CAS is `cas_n[1]`, low in Q4..Q5, and `cas_n[0]` stays high. `we_n[1]` (lane H) and `we_n[0]` (lane L) go low in Q3..Q5 for their enabled lanes.
- R6: With `strb_mode`=1 (two CAS), the shared write enable is `we_n[1]`, low in Q3..Q5, and `we_n[0]` stays high. `cas_n[1]` (lane H) and `cas_n[0]` (lane L) go low in Q4..Q5 for their enabled lanes.
- R7: `size`: 0 is byte, 1 is half-word, 2 or 3 is word. A byte access enables only lane H when addr[0]=0 and only lane L when addr[0]=1. Half-word and word accesses enable both lanes.
- R8: A word access runs two cycles with no idle clock between them. The first cycle uses half-word address {addr[20:2],0} and data wdata[31:16]. The second uses {addr[20:2],1} and data wdata[15:0].
- R9: `done` is high for exactly the one clock that follows Q5 of the last cycle of an access. The sequencer is idle during that clock.
- R10: While `rst_n` is low, the pins are in the idle state and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req | input | 1 | Write request |
| addr | input | 21 | Byte address |
| wdata | input | 32 | Write data |
| size | input | 2 | Access size code |
| strb_mode | input | 1 | 0 one-CAS, 1 two-CAS |
| ma | output | 11 | Multiplexed row/column address |
| dq_o | output | 16 | Data for D31..D16 |
| dq_oe | output | 1 | Data drive enable |
| cs_n | output | 1 | Chip select |
| ras_n | output | 1 | Row strobe |
| cas_n | output | 2 | Column strobe(s) |
| we_n | output | 2 | Write enable(s) |
| rd_n | output | 1 | Read strobe |
| done | output | 1 | Access complete pulse |

## Verification
The bench targets the following corner cases:
- Byte writes at both offsets in both strobe modes. A lane decode that is swapped or ignores the mode strobes the wrong byte lane or both lanes.
- Word writes at non-aligned addresses. Forgetting to clear addr[1] or swapping the halves shows up as a wrong column or wrong data in one of the two halves.
- A request held during a busy cycle. A design that queues or accepts it starts an extra cycle after `done`.
- Timing of `done`, and idle behaviour on the clock right after the last Q5.

// File: rtl/dram_wr_pkg.sv
package dram_wr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_Q1   = 3'd1,
    ST_Q2   = 3'd2,
    ST_Q3   = 3'd3,
    ST_Q4   = 3'd4,
    ST_Q5   = 3'd5
  } bus_st_t;

  // size code: 0 byte, 1 half-word, 2/3 word
  function automatic logic is_byte(input logic [1:0] sz);
    return sz == 2'd0;
  endfunction

  function automatic logic is_word(input logic [1:0] sz);
    return sz[1];
  endfunction

  // bit 1 = lane D31..D24, bit 0 = lane D23..D16
  function automatic logic [1:0] lane_sel(input logic [1:0] sz, input logic a0);
    if (is_byte(sz)) return a0 ? 2'b01 : 2'b10;
    return 2'b11;
  endfunction

  function automatic logic [15:0] bus_data(input logic [1:0] sz, input logic [31:0] wd,
                                           input logic second);
    if (is_byte(sz)) return {wd[7:0], wd[7:0]};
    if (is_word(sz) && !second) return wd[31:16];
    return wd[15:0];
  endfunction

endpackage

// File: rtl/dram_wr_ctl.sv
module dram_wr_ctl
  import dram_wr_pkg::*;
#(
  parameter int ADDR_W = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [1:0]        size,
  input  logic              strb_mode,
  output bus_st_t           st,
  output logic              second,
  output logic [ADDR_W-1:0] l_addr,
  output logic [31:0]       l_wdata,
  output logic [1:0]        l_size,
  output logic              l_mode,
  output logic              done
);

  logic accept;
  logic last_q5;

  assign accept  = (st == ST_IDLE) && req;
  assign last_q5 = (st == ST_Q5) && !(is_word(l_size) && !second);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      second  <= 1'b0;
      l_addr  <= '0;
      l_wdata <= '0;
      l_size  <= '0;
      l_mode  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= last_q5;
      unique case (st)
        ST_IDLE: if (accept) begin
          st      <= ST_Q1;
          second  <= 1'b0;
          l_addr  <= addr;
          l_wdata <= wdata;
          l_size  <= size;
          l_mode  <= strb_mode;
        end
        ST_Q1: st <= ST_Q2;
        ST_Q2: st <= ST_Q3;
        ST_Q3: st <= ST_Q4;
        ST_Q4: st <= ST_Q5;
        ST_Q5: begin
          if (last_q5) begin
            st     <= ST_IDLE;
            second <= 1'b0;
          end else begin
            st     <= ST_Q1;
            second <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  a_r1_q1_to_q2: assert property (@(posedge clk) disable iff (!rst_n) st == ST_Q1 |=> st == ST_Q2);
  a_r1_q2_to_q3: assert property (@(posedge clk) disable iff (!rst_n) st == ST_Q2 |=> st == ST_Q3);
  a_r1_q3_to_q4: assert property (@(posedge clk) disable iff (!rst_n) st == ST_Q3 |=> st == ST_Q4);
  a_r1_q4_to_q5: assert property (@(posedge clk) disable iff (!rst_n) st == ST_Q4 |=> st == ST_Q5);
  a_r1_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE) |=> $stable(l_addr) && $stable(l_wdata));
  a_r9_done_one_clock: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n) done |-> st == ST_IDLE);
  a_r8_second_word_only: assert property (@(posedge clk) disable iff (!rst_n)
    second |-> is_word(l_size));

endmodule

// File: rtl/dram_wr_pins.sv
module dram_wr_pins
  import dram_wr_pkg::*;
#(
  parameter int COL_W = 9,
  parameter int ROW_W = 11,
  localparam int ADDR_W = 1 + COL_W + ROW_W,
  localparam int MA_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_st_t           st,
  input  logic              second,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [31:0]       l_wdata,
  input  logic [1:0]        l_size,
  input  logic              l_mode,
  output logic [MA_W-1:0]   ma,
  output logic [15:0]       dq_o,
  output logic              dq_oe,
  output logic              cs_n,
  output logic              ras_n,
  output logic [1:0]        cas_n,
  output logic [1:0]        we_n
);

  logic              busy, ras_on, we_on, cas_on, col_phase;
  logic [ADDR_W-2:0] ha;
  logic [ROW_W-1:0]  row;
  logic [COL_W-1:0]  col;
  logic [1:0]        lanes;

  assign busy      = (st != ST_IDLE);
  assign ras_on    = (st == ST_Q2) || (st == ST_Q3) || (st == ST_Q4) || (st == ST_Q5);
  assign we_on     = (st == ST_Q3) || (st == ST_Q4) || (st == ST_Q5);
  assign cas_on    = (st == ST_Q4) || (st == ST_Q5);
  assign col_phase = we_on;

  assign ha  = is_word(l_size) ? {l_addr[ADDR_W-1:2], second} : l_addr[ADDR_W-1:1];
  assign col = ha[COL_W-1:0];
  assign row = ha[ADDR_W-2 -: ROW_W];
  assign lanes = lane_sel(l_size, l_addr[0]);

  always_comb begin
    ma = '0;
    if (busy) ma = col_phase ? MA_W'(col) : MA_W'(row);
  end

  assign dq_oe = busy;
  assign dq_o  = busy ? bus_data(l_size, l_wdata, second) : 16'h0000;
  assign cs_n  = ~busy;
  assign ras_n = ~ras_on;

  always_comb begin
    if (l_mode) begin
      cas_n = ~(lanes & {2{cas_on}});
      we_n  = {~we_on, 1'b1};
    end else begin
      cas_n = {~cas_on, 1'b1};
      we_n  = ~(lanes & {2{we_on}});
    end
  end

  a_r3_cas_under_ras: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_n != 2'b11) |-> !ras_n && !cs_n);
  a_r4_drive_with_we: assert property (@(posedge clk) disable iff (!rst_n)
    (we_n != 2'b11) |-> dq_oe);
  a_r2_col_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_Q4) |-> $stable(ma));
  a_r7_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_on && is_byte(l_size)) |-> $countones({~cas_n, ~we_n}) == 2);

endmodule

// File: rtl/dram_wr_seq.sv
module dram_wr_seq
  import dram_wr_pkg::*;
#(
  parameter int COL_W = 9,
  parameter int ROW_W = 11,
  localparam int ADDR_W = 1 + COL_W + ROW_W,
  localparam int MA_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [1:0]        size,
  input  logic              strb_mode,
  output logic [MA_W-1:0]   ma,
  output logic [15:0]       dq_o,
  output logic              dq_oe,
  output logic              cs_n,
  output logic              ras_n,
  output logic [1:0]        cas_n,
  output logic [1:0]        we_n,
  output logic              rd_n,
  output logic              done
);

  bus_st_t           st;
  logic              second;
  logic [ADDR_W-1:0] l_addr;
  logic [31:0]       l_wdata;
  logic [1:0]        l_size;
  logic              l_mode;

  dram_wr_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .wdata(wdata),
    .size(size), .strb_mode(strb_mode), .st(st), .second(second),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_size(l_size), .l_mode(l_mode),
    .done(done)
  );

  dram_wr_pins #(.COL_W(COL_W), .ROW_W(ROW_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .st(st), .second(second), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_size(l_size), .l_mode(l_mode), .ma(ma),
    .dq_o(dq_o), .dq_oe(dq_oe), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n)
  );

  assign rd_n = 1'b1;

endmodule

// File: tb/test_dram_wr_seq.sv
module test_dram_wr_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [20:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [1:0]  size = '0;
  logic        strb_mode = 1'b0;
  logic [10:0] ma;
  logic [15:0] dq_o;
  logic        dq_oe, cs_n, ras_n, rd_n, done;
  logic [1:0]  cas_n, we_n;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  dram_wr_seq i_dram_wr_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .wdata(wdata),
    .size(size), .strb_mode(strb_mode), .ma(ma), .dq_o(dq_o), .dq_oe(dq_oe),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .rd_n(rd_n),
    .done(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_ma(input int s, input int h, input int a, input int sz);
    int hw;
    if (s == 0) return 0;
    hw = (sz >= 2) ? ((a / 4) * 2 + h) : (a / 2);
    return (s >= 3) ? (hw % 512) : (hw / 512);
  endfunction

  function automatic int exp_data(input int h, input logic [31:0] wd, input int sz);
    if (sz == 0) return {16'h0, wd[7:0], wd[7:0]};
    if (sz >= 2 && h == 0) return {16'h0, wd[31:16]};
    return {16'h0, wd[15:0]};
  endfunction

  // returns {cas_n, we_n} for state s
  function automatic logic [3:0] exp_strb(input int s, input int a, input int sz, input int md);
    logic [1:0] ln;
    logic wo, co;
    ln = (sz != 0) ? 2'b11 : ((a % 2 == 1) ? 2'b01 : 2'b10);
    wo = (s >= 3);
    co = (s >= 4);
    if (md == 1) return {~(ln & {co, co}), ~wo, 1'b1};
    return {~co, 1'b1, ~(ln & {wo, wo})};
  endfunction

  task automatic chk_idle(input string tag, input logic exp_done);
    chk({tag, " pins"}, {ma, dq_o, dq_oe, cs_n, ras_n, cas_n, we_n, rd_n},
        {11'd0, 16'd0, 1'b0, 1'b1, 1'b1, 2'b11, 2'b11, 1'b1});
    chk({tag, " done"}, 32'(done), 32'(exp_done));
  endtask

  task automatic run_write(input int a, input logic [31:0] wd, input int sz, input int md,
                           input bit intrude);
    int nh;
    string mtag, dtag;
    addr = 21'(a); wdata = wd; size = 2'(sz); strb_mode = md[0]; req = 1'b1;
    @(posedge clk); @(negedge clk);
    req = 1'b0;
    nh = (sz >= 2) ? 2 : 1;
    mtag = (sz == 0) ? "R7" : ((md == 1) ? "R6" : "R5");
    for (int h = 0; h < nh; h++) begin
      for (int s = 1; s <= 5; s++) begin
        if (h == 0 && s == 1) chk("R1 start", 32'(cs_n), 32'd0);
        chk((h == 1) ? "R8 ma" : "R2 ma", 32'(ma), 32'(exp_ma(s, h, a, sz)));
        dtag = (h == 1) ? "R8 data" : "R4 data";
        chk(dtag, {15'd0, dq_oe, dq_o}, {15'd0, 1'b1, exp_data(h, wd, sz)[15:0]});
        chk("R3 ctl", {29'd0, cs_n, ras_n, rd_n}, {29'd0, 1'b0, (s == 1), 1'b1});
        chk(mtag, {28'd0, cas_n, we_n}, {28'd0, exp_strb(s, a, sz, md)});
        chk("R9 no early done", 32'(done), 32'd0);
        if (intrude && h == 0 && s == 3) begin
          req = 1'b1; addr = ~addr; size = 2'd0;
        end
        if (intrude && h == 0 && s == 4) req = 1'b0;
        @(posedge clk); @(negedge clk);
      end
    end
    chk_idle("R9 done cycle", 1'b1);
    @(posedge clk); @(negedge clk);
    chk_idle(intrude ? "R1 ignored" : "R9 after", 1'b0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd7341));
    repeat (3) @(negedge clk);
    chk_idle("R10 reset", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R10 after", 1'b0);
    // directed: bytes at both offsets, both modes
    run_write(21'h0A5F2, 32'h1234_56C3, 0, 0, 0);
    run_write(21'h0A5F3, 32'h1234_5677, 0, 0, 0);
    run_write(21'h1FFFE, 32'hDEAD_BE11, 0, 1, 0);
    run_write(21'h00001, 32'hDEAD_BE22, 0, 1, 0);
    // half and word, unaligned word address
    run_write(21'h12346, 32'hAAAA_5A5A, 1, 0, 0);
    run_write(21'h1FFFF, 32'hCAFE_F00D, 2, 0, 0);
    run_write(21'h00007, 32'h0123_4567, 3, 1, 0);
    // request while busy must be ignored
    run_write(21'h05554, 32'h8765_4321, 2, 1, 1);
    // random
    for (int i = 0; i < 40; i++) begin
      run_write(int'($urandom() % 32'h200000), $urandom(), int'($urandom() % 4),
                int'($urandom() % 2), ($urandom() % 4) == 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule